// File: doc/BRIEF.md
# Spread-Spectrum Link Frame Controller

This block handles byte framing on a direct-sequence spread-spectrum link. The despreader, modulator and code-phase tracking sit outside it. The link runs in one of two directions at a time, and it normally sits in receive.

Software starts a transmission by setting the mode bit in the status register. The block then drives a run of all-ones periods so that the far end can acquire code phase. It follows this with a fixed frame-start word. After that it sends the bytes the processor supplies through a single one-byte buffer. When the buffer runs dry after at least one byte, the block drops back to receive by itself. If no byte arrives in time after entry, it also falls back to receive.

In receive, the block watches a per-period data bit while the despreader reports code lock. It slides a window over the bits until the frame-start word appears, then packs every eight following bits into a byte for the processor. Every byte hand-over raises a one-cycle interrupt, in both directions.

Top module: `dsss_frame_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, and `tx_active_o` and `irq_o` are low.
- R2: A write of 1 to status bit 0 (address 0) while receiving enters transmit. Status bit 0 then reads 1, and status bit 1 (buffer empty) reads 1.
- R3: The first PRE_LEN code periods (default 40) of a transmission carry a 1 on `tx_bit_o`.
- R4: The next 8 periods carry FRAME_WORD (default 0x1A), most significant bit first.
- R5: Data bytes follow, most significant bit first, one bit per period, in the order they were written. When each byte is written before the previous one finishes, the bytes run back to back with no gap.
- R6: At each byte boundary a buffered byte moves into the shifter. At that point status bit 1 returns to 1 and `irq_o` pulses. A write to the data register (address 1) while the buffer is full is dropped.
- R7: When a byte boundary finds the buffer empty after at least one byte has been sent, the unit returns to receive. This happens right after the last bit period of the final byte.
- R8: If no data write follows entry into transmit within TMO_MS milliseconds (CLK_HZ/1000 clock cycles per ms), the unit returns to receive. It stays in transmit before that time.
- R9: A write with bit 0 = 0 to the status register forces receive at the next clock edge, aborting any transmission. It also restarts the frame search, clearing status bit 2.
- R10: While `rx_sync_i` is high, once FRAME_WORD has been seen, each further group of 8 bits is stored in the data register, most significant bit first. Status bit 1 (byte ready) and status bit 2 (in frame) then read 1, and `irq_o` pulses once per byte.
- R11: Bits that do not complete FRAME_WORD deliver nothing. A low level on `rx_sync_i` ends the frame and restarts the search.
- R12: A read of the data register clears status bit 1 in receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 1 | Register select: 0 status, 1 data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| tick_i | input | 1 | One-cycle pulse per code period |
| rx_sync_i | input | 1 | Despreader code lock |
| rx_bit_i | input | 1 | Despread data bit, valid with `tick_i` |
| tx_active_o | output | 1 | High while transmitting |
| tx_bit_o | output | 1 | Data bit for the current code period |
| irq_o | output | 1 | Byte hand-over pulse |

## Verification
The bench captures the whole transmitted bit stream and compares it against an expected stream that it builds itself. A design that miscounts the preamble, reverses the frame word or shifts data least significant bit first fails on a specific region of that stream. The same stream is then fed back into the receiver, which must recover the original bytes. Directed cases cover the following:
- A second write into a full buffer, where a design without the drop would add an extra byte.
- The timeout window, which is probed both before and after expiry.
- Noise that holds no frame word, and frame search restarted by a status write.
- Loss of code lock in the middle of a frame, after which a design that kept its byte counter would deliver bytes without a new frame word.

// File: rtl/dsss_frm_pkg.sv
package dsss_frm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
  localparam int unsigned ST_MODE  = 0;
  localparam int unsigned ST_FLAG  = 1;
  localparam int unsigned ST_FRAME = 2;

  typedef enum logic [2:0] {
    TX_IDLE, TX_PRE, TX_MARK, TX_SEND, TX_WAIT
  } tx_phase_e;
endpackage

// File: rtl/dsss_tx_timeout.sv
module dsss_tx_timeout #(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned TMO_MS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic clear_i,
  output logic fire_o
);
  localparam int unsigned PRESC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int unsigned PW = $clog2(PRESC) + 1;
  localparam int unsigned MW = $clog2(TMO_MS) + 1;

  logic          armed_q;
  logic [PW-1:0] pcnt_q;
  logic [MW-1:0] mcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pcnt_q  <= '0;
      mcnt_q  <= '0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (arm_i) begin
        armed_q <= 1'b1;
        pcnt_q  <= '0;
        mcnt_q  <= '0;
      end else if (clear_i) begin
        armed_q <= 1'b0;
      end else if (armed_q) begin
        if (pcnt_q == PW'(PRESC - 1)) begin
          pcnt_q <= '0;
          if (mcnt_q == MW'(TMO_MS - 1)) begin
            fire_o  <= 1'b1;
            armed_q <= 1'b0;
          end else begin
            mcnt_q <= mcnt_q + 1'b1;
          end
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsss_tx_seq.sv
module dsss_tx_seq
  import dsss_frm_pkg::*;
#(
  parameter int unsigned        PRE_LEN    = 40,
  parameter logic [BYTE_W-1:0]  FRAME_WORD = 8'h1A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              active_o,
  output logic              bit_o,
  output logic              buf_empty_o,
  output logic              load_o
);
  localparam int unsigned CW = ($clog2(PRE_LEN) > 3) ? $clog2(PRE_LEN) : 3;

  tx_phase_e         phase_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sh_q, buf_q;
  logic              full_q, sent_q;
  logic              wr_ok, slot;
  logic [BYTE_W-1:0] mark_sh;

  assign active_o    = (phase_q != TX_IDLE);
  assign buf_empty_o = !full_q;
  assign wr_ok       = wr_i && active_o && !full_q;
  // byte boundary: end of marker, end of a byte, or any period while starved
  assign slot = tick_i && ((((phase_q == TX_MARK) || (phase_q == TX_SEND)) &&
                           (cnt_q == CW'(BYTE_W - 1))) || (phase_q == TX_WAIT));
  assign mark_sh = FRAME_WORD << cnt_q[2:0];

  always_comb begin
    unique case (phase_q)
      TX_PRE, TX_WAIT: bit_o = 1'b1;
      TX_MARK:         bit_o = mark_sh[BYTE_W-1];
      TX_SEND:         bit_o = sh_q[BYTE_W-1];
      default:         bit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= TX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      buf_q   <= '0;
      full_q  <= 1'b0;
      sent_q  <= 1'b0;
      load_o  <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (abort_i) begin
        phase_q <= TX_IDLE;
        full_q  <= 1'b0;
      end else if (start_i && !active_o) begin
        phase_q <= TX_PRE;
        cnt_q   <= '0;
        full_q  <= 1'b0;
        sent_q  <= 1'b0;
      end else begin
        if (wr_ok) begin
          buf_q  <= wdata_i;
          full_q <= 1'b1;
        end
        if (tick_i) begin
          unique case (phase_q)
            TX_PRE: begin
              if (cnt_q == CW'(PRE_LEN - 1)) begin
                phase_q <= TX_MARK;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            TX_MARK: cnt_q <= cnt_q + 1'b1;
            TX_SEND: begin
              cnt_q <= cnt_q + 1'b1;
              sh_q  <= sh_q << 1;
            end
            default: ;
          endcase
        end
        if (slot) begin
          if (full_q) begin
            sh_q    <= buf_q;
            full_q  <= 1'b0;
            sent_q  <= 1'b1;
            load_o  <= 1'b1;
            phase_q <= TX_SEND;
            cnt_q   <= '0;
          end else if (sent_q) begin
            phase_q <= TX_IDLE;
          end else begin
            phase_q <= TX_WAIT;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dsss_rx_deframe.sv
module dsss_rx_deframe
  import dsss_frm_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FRAME_WORD = 8'h1A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic              sync_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_stb_o,
  output logic              framed_o
);
  localparam int unsigned BW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] win_q, win_nxt;
  logic [BW-1:0]     cnt_q;

  assign win_nxt = {win_q[BYTE_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q      <= '1;
      cnt_q      <= '0;
      framed_o   <= 1'b0;
      byte_o     <= '0;
      byte_stb_o <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0;
      if (restart_i || !sync_i) begin
        // window preset to ones: a marker with MSB 0 needs 8 fresh bits
        win_q    <= '1;
        cnt_q    <= '0;
        framed_o <= 1'b0;
      end else if (tick_i) begin
        win_q <= win_nxt;
        if (!framed_o) begin
          if (win_nxt == FRAME_WORD) begin
            framed_o <= 1'b1;
            cnt_q    <= '0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == BW'(BYTE_W - 1)) begin
            byte_o     <= win_nxt;
            byte_stb_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dsss_frame_ctrl.sv
module dsss_frame_ctrl
  import dsss_frm_pkg::*;
#(
  parameter int unsigned       PRE_LEN    = 40,
  parameter logic [BYTE_W-1:0] FRAME_WORD = 8'h1A,
  parameter int unsigned       CLK_HZ     = 200_000_000,
  parameter int unsigned       TMO_MS     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              tick_i,
  input  logic              rx_sync_i,
  input  logic              rx_bit_i,
  output logic              tx_active_o,
  output logic              tx_bit_o,
  output logic              irq_o
);
  logic go_tx, force_rx, data_wr, data_rd;
  logic tmo_fire, buf_empty, tx_load;
  logic rx_stb, framed, rx_ready_q;
  logic [BYTE_W-1:0] rx_byte, rx_data_q, status;

  assign go_tx    = reg_we_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[ST_MODE] && !tx_active_o;
  assign force_rx = reg_we_i && (reg_addr_i == ADDR_STAT) && !reg_wdata_i[ST_MODE];
  assign data_wr  = reg_we_i && (reg_addr_i == ADDR_DATA);
  assign data_rd  = reg_re_i && (reg_addr_i == ADDR_DATA);

  dsss_tx_timeout #(.CLK_HZ(CLK_HZ), .TMO_MS(TMO_MS)) u_tmo (
    .clk_i, .rst_ni,
    .arm_i   (go_tx),
    .clear_i (data_wr && tx_active_o),
    .fire_o  (tmo_fire)
  );

  dsss_tx_seq #(.PRE_LEN(PRE_LEN), .FRAME_WORD(FRAME_WORD)) u_tx (
    .clk_i, .rst_ni,
    .start_i     (go_tx),
    .abort_i     (force_rx || tmo_fire),
    .tick_i,
    .wr_i        (data_wr),
    .wdata_i     (reg_wdata_i),
    .active_o    (tx_active_o),
    .bit_o       (tx_bit_o),
    .buf_empty_o (buf_empty),
    .load_o      (tx_load)
  );

  dsss_rx_deframe #(.FRAME_WORD(FRAME_WORD)) u_rx (
    .clk_i, .rst_ni,
    .restart_i  (force_rx || tx_active_o),
    .tick_i,
    .sync_i     (rx_sync_i),
    .bit_i      (rx_bit_i),
    .byte_o     (rx_byte),
    .byte_stb_o (rx_stb),
    .framed_o   (framed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q  <= '0;
      rx_ready_q <= 1'b0;
    end else if (rx_stb) begin
      rx_data_q  <= rx_byte;
      rx_ready_q <= 1'b1;
    end else if (data_rd) begin
      rx_ready_q <= 1'b0;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_MODE]  = tx_active_o;
    status[ST_FLAG]  = tx_active_o ? buf_empty : rx_ready_q;
    status[ST_FRAME] = framed;
  end

  assign reg_rdata_o = (reg_addr_i == ADDR_STAT) ? status : rx_data_q;
  assign irq_o       = tx_load || rx_stb;
endmodule

// File: rtl/dsss_frame_ctrl_chk.sv
module dsss_frame_ctrl_chk
  import dsss_frm_pkg::*;
#(
  parameter int unsigned PRE_LEN = 40,
  parameter int unsigned CLK_HZ  = 200_000_000,
  parameter int unsigned TMO_MS  = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic reg_addr_i,
  input logic reg_we_i,
  input logic wr_bit0_i,
  input logic tick_i,
  input logic tx_active_o,
  input logic tx_bit_o,
  input logic irq_o
);
  localparam int unsigned TMO_CYC = ((CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1) * TMO_MS;
  localparam int unsigned IW = $clog2(TMO_CYC + 4) + 1;
  localparam int unsigned PW = $clog2(PRE_LEN + 1) + 1;

  logic [PW-1:0] pre_q;
  logic [IW-1:0] idle_q;
  logic          wrote_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      idle_q  <= '0;
      wrote_q <= 1'b0;
    end else if (!tx_active_o) begin
      pre_q   <= '0;
      idle_q  <= '0;
      wrote_q <= 1'b0;
    end else begin
      if (tick_i && (pre_q < PW'(PRE_LEN))) pre_q <= pre_q + 1'b1;
      if (idle_q != '1) idle_q <= idle_q + 1'b1;
      if (reg_we_i && (reg_addr_i == ADDR_DATA)) wrote_q <= 1'b1;
    end
  end

  a_r2_entry_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active_o) |-> $past(reg_we_i && (reg_addr_i == ADDR_STAT) && wr_bit0_i));

  a_r9_force_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_addr_i == ADDR_STAT) && !wr_bit0_i) |=> !tx_active_o);

  a_r3_preamble_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_active_o && (pre_q < PW'(PRE_LEN))) |-> tx_bit_o);

  a_r8_timeout_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_active_o && !wrote_q && (idle_q > IW'(TMO_CYC + 1))));

  a_r6_irq_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));
endmodule

bind dsss_frame_ctrl dsss_frame_ctrl_chk #(
  .PRE_LEN (PRE_LEN),
  .CLK_HZ  (CLK_HZ),
  .TMO_MS  (TMO_MS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .wr_bit0_i   (reg_wdata_i[0]),
  .tick_i      (tick_i),
  .tx_active_o (tx_active_o),
  .tx_bit_o    (tx_bit_o),
  .irq_o       (irq_o)
);

// File: tb/dsss_frame_ctrl_test.sv
`timescale 1ns/1ps
module dsss_frame_ctrl_test;
  localparam int unsigned PRE    = 40;
  localparam logic [7:0]  FRAME  = 8'h1A;
  localparam int unsigned CLK_HZ = 20_000;
  localparam int unsigned TMO_MS = 4;

  logic clk, rst_n, reg_addr, reg_we, reg_re, tick, rx_sync, rx_bit;
  logic [7:0] reg_wdata, reg_rdata;
  logic tx_active, tx_bit, irq;

  int checks = 0, errors = 0;
  int irq_tx_cnt = 0, irq_rx_cnt = 0;
  int phase_c = 0;
  bit tick_en = 0;
  bit got_q[$];
  bit rx_q[$];
  bit lb_bits[$];
  logic [7:0] lb_bytes[$];

  dsss_frame_ctrl #(.PRE_LEN(PRE), .FRAME_WORD(FRAME), .CLK_HZ(CLK_HZ), .TMO_MS(TMO_MS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .tick_i(tick), .rx_sync_i(rx_sync),
    .rx_bit_i(rx_bit), .tx_active_o(tx_active), .tx_bit_o(tx_bit), .irq_o(irq)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  // code-period ticks every 4 cycles; receive bits popped from rx_q
  initial begin
    tick = 1'b0;
    rx_bit = 1'b0;
    forever begin
      @(negedge clk);
      phase_c = (phase_c + 1) % 4;
      tick = (phase_c == 0) && (tick_en || rx_q.size() != 0);
      if (tick && !tick_en && rx_q.size() != 0) rx_bit = rx_q.pop_front();
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (tick && tx_active) got_q.push_back(tx_bit);
      if (irq) begin
        if (tx_active) irq_tx_cnt++;
        else irq_rx_cnt++;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  function automatic int count_diff(input bit a[$], input bit b[$], input int lo, input int hi);
    int n = 0;
    for (int i = lo; i < hi; i++)
      if (i >= a.size() || i >= b.size() || a[i] != b[i]) n++;
    return n;
  endfunction

  function automatic void build_exp(input logic [7:0] data[$], ref bit e[$]);
    e.delete();
    for (int i = 0; i < PRE; i++) e.push_back(1'b1);
    for (int i = 7; i >= 0; i--) e.push_back(FRAME[i]);
    foreach (data[k])
      for (int i = 7; i >= 0; i--) e.push_back(data[k][i]);
  endfunction

  task automatic run_tx(input logic [7:0] data[$], input bit try_drop);
    logic [7:0] s;
    bit exp_q[$];
    int irq0, guard;
    got_q.delete();
    irq0 = irq_tx_cnt;
    tick_en = 1;
    wr(1'b0, 8'h01);
    rd(1'b0, s);
    chk("R2", "mode bit after entry", s[0], 1);
    chk("R2", "buffer empty after entry", s[1], 1);
    foreach (data[k]) begin
      guard = 0;
      rd(1'b0, s);
      while (!s[1] && guard < 1000) begin
        rd(1'b0, s);
        guard++;
      end
      wr(1'b1, data[k]);
      if (try_drop && k == 0) begin
        rd(1'b0, s);
        chk("R6", "buffer empty after write", s[1], 0);
        wr(1'b1, ~data[0]);
      end
    end
    guard = 0;
    while (tx_active && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    tick_en = 0;
    build_exp(data, exp_q);
    chk("R3", "preamble mismatches", count_diff(got_q, exp_q, 0, PRE), 0);
    chk("R4", "marker mismatches", count_diff(got_q, exp_q, PRE, PRE + 8), 0);
    chk("R5", "data mismatches", count_diff(got_q, exp_q, PRE + 8, exp_q.size()), 0);
    chk("R7", "periods sent before receive", got_q.size(), exp_q.size());
    chk("R6", "load interrupts", irq_tx_cnt - irq0, data.size());
    rd(1'b0, s);
    chk("R7", "mode bit after last byte", s[0], 0);
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) rx_q.push_back(b[i]);
  endtask

  task automatic push_ones(input int n);
    for (int i = 0; i < n; i++) rx_q.push_back(1'b1);
  endtask

  task automatic drain();
    while (rx_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic rx_expect(input logic [7:0] b, input string req);
    logic [7:0] s, d;
    push_byte(b);
    drain();
    rd(1'b0, s);
    chk(req, "byte ready", s[1], 1);
    rd(1'b1, d);
    chk(req, "received byte", d, b);
    rd(1'b0, s);
    chk("R12", "ready after data read", s[1], 0);
  endtask

  initial begin
    logic [7:0] s, b;
    logic [7:0] data[$];
    int irq0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_addr = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_wdata = '0; rx_sync = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd(1'b0, s);
    chk("R1", "status after reset", s, 8'h00);
    chk("R1", "tx_active after reset", tx_active, 0);
    chk("R1", "irq after reset", irq, 0);

    // random multi-byte frame, kept for loopback
    data.delete();
    for (int i = 0; i < 3; i++) data.push_back(8'($urandom));
    run_tx(data, 1'b0);
    lb_bits = got_q;
    lb_bytes = data;

    // single byte with a dropped overwrite
    data.delete();
    data.push_back(8'($urandom));
    run_tx(data, 1'b1);

    // longer frame including corner values
    data.delete();
    data.push_back(8'h00); data.push_back(8'hFF);
    for (int i = 0; i < 3; i++) data.push_back(8'($urandom));
    run_tx(data, 1'b0);

    // first-byte timeout (80 cycles with these parameters)
    tick_en = 1;
    wr(1'b0, 8'h01);
    repeat (55) @(negedge clk);
    chk("R8", "still transmitting before timeout", tx_active, 1);
    repeat (45) @(negedge clk);
    chk("R8", "receive after timeout", tx_active, 0);
    rd(1'b0, s);
    chk("R8", "mode bit after timeout", s[0], 0);

    // forced receive aborts transmit
    wr(1'b0, 8'h01);
    repeat (20) @(negedge clk);
    chk("R9", "transmitting before abort", tx_active, 1);
    wr(1'b0, 8'h00);
    chk("R9", "receive after status write", tx_active, 0);
    tick_en = 0;
    repeat (8) @(negedge clk);

    // receive: noise without the frame word
    rx_sync = 1'b1;
    wr(1'b0, 8'h00);
    push_byte(8'h55); push_byte(8'hC3);
    drain();
    rd(1'b0, s);
    chk("R11", "frame flag after noise", s[2], 0);
    chk("R11", "ready after noise", s[1], 0);

    push_ones(PRE); push_byte(FRAME);
    drain();
    rd(1'b0, s);
    chk("R10", "frame flag after marker", s[2], 1);
    irq0 = irq_rx_cnt;
    for (int i = 0; i < 3; i++) rx_expect(8'($urandom), "R10");
    chk("R10", "receive interrupts", irq_rx_cnt - irq0, 3);

    // status write restarts search
    wr(1'b0, 8'h00);
    rd(1'b0, s);
    chk("R9", "frame flag after restart", s[2], 0);
    b = 8'($urandom);
    if (b == FRAME) b = b ^ 8'h01;
    push_byte(b);
    drain();
    rd(1'b0, s);
    chk("R9", "no delivery while searching", s[1], 0);

    // loss of code lock mid-frame
    push_ones(PRE); push_byte(FRAME);
    drain();
    rd(1'b0, s);
    chk("R10", "frame flag relocked", s[2], 1);
    rx_sync = 1'b0;
    repeat (3) @(negedge clk);
    rx_sync = 1'b1;
    rd(1'b0, s);
    chk("R11", "frame flag after lock loss", s[2], 0);
    push_byte(b);
    drain();
    rd(1'b0, s);
    chk("R11", "no delivery after lock loss", s[1], 0);

    // loopback of the first transmitted stream
    wr(1'b0, 8'h00);
    for (int i = 0; i < PRE + 8; i++) rx_q.push_back(lb_bits.pop_front());
    drain();
    rd(1'b0, s);
    chk("R10", "loopback frame flag", s[2], 1);
    foreach (lb_bytes[k]) begin
      logic [7:0] d;
      for (int i = 0; i < 8; i++) rx_q.push_back(lb_bits.pop_front());
      drain();
      rd(1'b1, d);
      chk("R5", "loopback byte", d, lb_bytes[k]);
    end

    finish_run();
  end
endmodule